// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block paces the external memory bus of a small 8-bit controller. It runs on the oscillator-rate clock. It splits each machine cycle into slots and generates from them the address-latch strobe and the active-low program-read strobe. It also steers the multiplexed low address/data port and the high address port. A machine cycle is 12 clocks in normal mode and 6 clocks in double-speed mode. Each machine cycle has two halves, and every half opens with an address-latch slot window.

Code fetches use the external bus in two cases: when the external-access pin is low, or when the program counter is above the internal code limit. A data access is requested by the core at a machine-cycle boundary. It takes over the next machine cycle. Its address is latched in the first half, and the second half is the data phase. In that cycle the second latch pulse and both program-read pulses are suppressed. The high port carries the full upper address byte for 16-bit data accesses. It carries the high-port register value for 8-bit data accesses.

Top module: `xbus_strobe_seq`

## Requirements
- R1: While `rst_n` is low, `ale_o`=0, `psen_n_o`=1, `ad_oe_o`=0 and `ahi_oe_o`=0. The first rising clock edge after release starts machine-cycle slot 0.
- R2: In normal mode the latch strobe is high in half-cycle positions 0–1, which are slots 0,1,6,7 of 12. In double-speed mode it is high in position 0, which is slots 0,3 of 6. This gives one pulse every 6 or every 3 clocks.
- R3: On an external fetch, `psen_n_o` is low in half-cycle positions above the latch width: slots 3–5 and 9–11 in normal mode, slots 2 and 5 in double-speed mode. It is never low in the same slot as a high `ale_o`.
- R4: A fetch half is external when `ext_acc_i` is 0 or `pc_i` > 0x1FFF. An internal fetch keeps `psen_n_o` high and both ports undriven.
- R5: When `ale_off_i` is 1, `ale_o` stays low for internal fetch cycles. External fetches and data cycles still pulse.
- R6: In a data cycle, `ale_o` pulses only in the first half, and `psen_n_o` stays high for the whole machine cycle.
- R7: The low port drives `pc[7:0]` while `ale_o` is high on external fetches, and is released otherwise. In a data cycle it drives the data address low byte while the first-half latch window is open, drives `dx_wdata_i` for the whole second half when writing, and stays released when reading. `ad_o` reads 0 while undriven.
- R8: `ahi_oe_o` is 1 on external fetches and on data cycles. `ahi_o` carries `pc[15:8]` on fetches, `dx_addr_i[15:8]` when `dx_wide_i`=1, and `hi_reg_i` otherwise.
- R9: The inputs `dbl_speed_i`, `ale_off_i`, the `dx_*` inputs and `hi_reg_i` are sampled only at the last slot of a machine cycle. Changes to them mid-cycle have no effect. `ext_acc_i` and `pc_i` are sampled at the last slot of each half.
- R10: A mode change takes effect at the next machine-cycle boundary. This includes a boundary that also starts a data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbl_speed_i | input | 1 | 1 selects 6-clock machine cycles |
| ale_off_i | input | 1 | Suppress latch strobe on internal fetches |
| ext_acc_i | input | 1 | External-access pin level, 0 forces external fetch |
| pc_i | input | 16 | Program counter |
| dx_req_i | input | 1 | Data access request for next machine cycle |
| dx_wide_i | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| dx_write_i | input | 1 | 1 = write, 0 = read |
| dx_addr_i | input | 16 | Data access address |
| dx_wdata_i | input | 8 | Write data |
| hi_reg_i | input | 8 | High-port register value |
| ale_o | output | 1 | Address-latch strobe |
| psen_n_o | output | 1 | Program-read strobe, active low |
| ad_o | output | 8 | Low address/data port value |
| ad_oe_o | output | 1 | Low port drive enable |
| ahi_o | output | 8 | High address port value |
| ahi_oe_o | output | 1 | High port drive enable |

## Verification
Two things can happen at the same machine-cycle boundary: a speed-mode change and the start of a data access. The bench provokes this by raising `dbl_speed_i` and `dx_req_i` together in the last slot of a cycle, and then lowering speed together with a new narrow request. The scoreboard expects the data cycle to run at the new slot count. It expects a single latch pulse in the first half of that shorter cycle, no program-read pulse, and a high port holding the data address. A separate cycle toggles speed, latch-disable and request in the middle of a machine cycle. This checks that only the boundary sample matters.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  // Data-access context held for one machine cycle
  typedef struct packed {
    logic              active;
    logic              wide;
    logic              write;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wdata;
    logic [BYTE_W-1:0] hreg;
  } dx_ctx_t;
endpackage

// File: rtl/xbus_slot_ctr.sv
`timescale 1ns/1ps
module xbus_slot_ctr #(
  parameter int BASE_SLOTS = 12,
  localparam int CW = $clog2(BASE_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbl_i,
  output logic          live_o,
  output logic          x2_o,
  output logic          upper_o,
  output logic [CW-1:0] pos_o,
  output logic          half_end_o,
  output logic          mc_end_o
);
  localparam logic [CW-1:0] LAST_N = CW'(BASE_SLOTS - 1);
  localparam logic [CW-1:0] LAST_X = CW'(BASE_SLOTS / 2 - 1);
  localparam logic [CW-1:0] HALF_N = CW'(BASE_SLOTS / 2);
  localparam logic [CW-1:0] HALF_X = CW'(BASE_SLOTS / 4);

  logic          live_q, live_d;
  logic          x2_q, x2_d;
  logic [CW-1:0] slot_q, slot_d;
  logic [CW-1:0] last, half;

  always_comb begin
    last       = x2_q ? LAST_X : LAST_N;
    half       = x2_q ? HALF_X : HALF_N;
    mc_end_o   = live_q && (slot_q == last);
    upper_o    = (slot_q >= half);
    pos_o      = upper_o ? (slot_q - half) : slot_q;
    half_end_o = live_q && (pos_o == half - 1'b1);
    live_o     = live_q;
    x2_o       = x2_q;
  end

  always_comb begin
    live_d = 1'b1;
    x2_d   = x2_q;
    slot_d = slot_q + 1'b1;
    if (!live_q || mc_end_o) begin
      x2_d   = dbl_i;
      slot_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      x2_q   <= 1'b0;
      slot_q <= '0;
    end else begin
      live_q <= live_d;
      x2_q   <= x2_d;
      slot_q <= slot_d;
    end
  end

  p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q <= last);
endmodule

// File: rtl/xbus_ctx.sv
`timescale 1ns/1ps
module xbus_ctx
  import xbus_pkg::*;
#(
  parameter logic [ADDR_W-1:0] INT_TOP = 16'h1FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_i,
  input  logic              half_end_i,
  input  logic              mc_end_i,
  input  logic              ext_acc_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              ale_off_i,
  input  logic              dx_req_i,
  input  logic              dx_wide_i,
  input  logic              dx_write_i,
  input  logic [ADDR_W-1:0] dx_addr_i,
  input  logic [BYTE_W-1:0] dx_wdata_i,
  input  logic [BYTE_W-1:0] hi_reg_i,
  output logic              ext_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              ale_off_o,
  output dx_ctx_t           dx_o
);
  logic              fetch_en, data_en;
  logic              ext_q, ext_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              off_q, off_d;
  dx_ctx_t           dx_q, dx_d;

  always_comb begin
    fetch_en = !live_i || half_end_i;
    data_en  = !live_i || mc_end_i;
    ext_d    = ext_q;
    pc_d     = pc_q;
    off_d    = off_q;
    dx_d     = dx_q;
    if (fetch_en) begin
      ext_d = !ext_acc_i || (pc_i > INT_TOP);
      pc_d  = pc_i;
    end
    if (data_en) begin
      off_d        = ale_off_i;
      dx_d.active  = dx_req_i;
      dx_d.wide    = dx_wide_i;
      dx_d.write   = dx_write_i;
      dx_d.addr    = dx_addr_i;
      dx_d.wdata   = dx_wdata_i;
      dx_d.hreg    = hi_reg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      pc_q  <= '0;
      off_q <= 1'b0;
      dx_q  <= '0;
    end else begin
      ext_q <= ext_d;
      pc_q  <= pc_d;
      off_q <= off_d;
      dx_q  <= dx_d;
    end
  end

  assign ext_o     = ext_q;
  assign pc_o      = pc_q;
  assign ale_off_o = off_q;
  assign dx_o      = dx_q;
endmodule

// File: rtl/xbus_drive.sv
`timescale 1ns/1ps
module xbus_drive
  import xbus_pkg::*;
#(
  parameter int BASE_SLOTS = 12,
  localparam int CW = $clog2(BASE_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_i,
  input  logic              x2_i,
  input  logic              upper_i,
  input  logic [CW-1:0]     pos_i,
  input  logic              ext_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic              ale_off_i,
  input  dx_ctx_t           dx_i,
  output logic              ale_o,
  output logic              psen_n_o,
  output logic [BYTE_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic [BYTE_W-1:0] ahi_o,
  output logic              ahi_oe_o
);
  // latch window is one third of a half cycle
  localparam logic [CW-1:0] AW_N = CW'(BASE_SLOTS / 6);
  localparam logic [CW-1:0] AW_X = CW'(BASE_SLOTS / 12);

  logic [CW-1:0] aw;
  logic          ale_slot, psen_slot;

  always_comb begin
    aw        = x2_i ? AW_X : AW_N;
    ale_slot  = live_i && (pos_i < aw);
    psen_slot = live_i && (pos_i > aw);
    ale_o     = 1'b0;
    psen_n_o  = 1'b1;
    ad_oe_o   = 1'b0;
    ad_o      = '0;
    ahi_oe_o  = 1'b0;
    ahi_o     = dx_i.hreg;
    if (live_i) begin
      if (dx_i.active) begin
        ale_o    = ale_slot && !upper_i;
        ad_oe_o  = upper_i ? dx_i.write : ale_slot;
        if (ad_oe_o)
          ad_o   = upper_i ? dx_i.wdata : dx_i.addr[BYTE_W-1:0];
        ahi_oe_o = 1'b1;
        ahi_o    = dx_i.wide ? dx_i.addr[ADDR_W-1:BYTE_W] : dx_i.hreg;
      end else begin
        ale_o    = ale_slot && (ext_i || !ale_off_i);
        psen_n_o = !(psen_slot && ext_i);
        ad_oe_o  = ale_slot && ext_i;
        if (ad_oe_o)
          ad_o   = pc_i[BYTE_W-1:0];
        ahi_oe_o = ext_i;
        if (ext_i)
          ahi_o  = pc_i[ADDR_W-1:BYTE_W];
      end
    end
  end

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale_o && !psen_n_o));
  p_int_no_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && !ext_i) |-> psen_n_o);
  p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_off_i && !ext_i && !dx_i.active) |-> !ale_o);
  p_data_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dx_i.active |-> psen_n_o);
  p_data_one_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dx_i.active && upper_i) |-> !ale_o);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ale_o && $past(ale_o)) |-> $stable(ad_o));
  p_hi_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && ext_i) |-> ahi_oe_o);
endmodule

// File: rtl/xbus_strobe_seq.sv
`timescale 1ns/1ps
module xbus_strobe_seq #(
  parameter int          BASE_SLOTS = 12,
  parameter logic [15:0] INT_TOP    = 16'h1FFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbl_speed_i,
  input  logic        ale_off_i,
  input  logic        ext_acc_i,
  input  logic [15:0] pc_i,
  input  logic        dx_req_i,
  input  logic        dx_wide_i,
  input  logic        dx_write_i,
  input  logic [15:0] dx_addr_i,
  input  logic [7:0]  dx_wdata_i,
  input  logic [7:0]  hi_reg_i,
  output logic        ale_o,
  output logic        psen_n_o,
  output logic [7:0]  ad_o,
  output logic        ad_oe_o,
  output logic [7:0]  ahi_o,
  output logic        ahi_oe_o
);
  import xbus_pkg::*;
  localparam int CW = $clog2(BASE_SLOTS);

  logic              live, x2, upper, half_end, mc_end;
  logic [CW-1:0]     pos;
  logic              ext_q, off_q;
  logic [ADDR_W-1:0] pc_q;
  dx_ctx_t           dx_q;

  xbus_slot_ctr #(.BASE_SLOTS(BASE_SLOTS)) u_slot (
    .clk(clk), .rst_n(rst_n), .dbl_i(dbl_speed_i),
    .live_o(live), .x2_o(x2), .upper_o(upper), .pos_o(pos),
    .half_end_o(half_end), .mc_end_o(mc_end)
  );

  xbus_ctx #(.INT_TOP(INT_TOP)) u_ctx (
    .clk(clk), .rst_n(rst_n), .live_i(live), .half_end_i(half_end),
    .mc_end_i(mc_end), .ext_acc_i(ext_acc_i), .pc_i(pc_i),
    .ale_off_i(ale_off_i), .dx_req_i(dx_req_i), .dx_wide_i(dx_wide_i),
    .dx_write_i(dx_write_i), .dx_addr_i(dx_addr_i), .dx_wdata_i(dx_wdata_i),
    .hi_reg_i(hi_reg_i), .ext_o(ext_q), .pc_o(pc_q), .ale_off_o(off_q),
    .dx_o(dx_q)
  );

  xbus_drive #(.BASE_SLOTS(BASE_SLOTS)) u_drive (
    .clk(clk), .rst_n(rst_n), .live_i(live), .x2_i(x2), .upper_i(upper),
    .pos_i(pos), .ext_i(ext_q), .pc_i(pc_q), .ale_off_i(off_q), .dx_i(dx_q),
    .ale_o(ale_o), .psen_n_o(psen_n_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ahi_o(ahi_o), .ahi_oe_o(ahi_oe_o)
  );
endmodule

// File: tb/tb_xbus_strobe_seq.sv
`timescale 1ns/1ps
module tb_xbus_strobe_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbl = 1'b0, aoff = 1'b0, ea = 1'b0;
  logic [15:0] pc = '0;
  logic        dreq = 1'b0, dwide = 1'b0, dwr = 1'b0;
  logic [15:0] daddr = '0;
  logic [7:0]  dwd = '0, p2 = '0;
  logic        ale, psen_n, ad_oe, ahi_oe;
  logic [7:0]  ad, ahi;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic       ale, psen_n, ad_oe, ahi_oe;
    logic [7:0] ad, ahi;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  xbus_strobe_seq dut (
    .clk(clk), .rst_n(rst_n), .dbl_speed_i(dbl), .ale_off_i(aoff),
    .ext_acc_i(ea), .pc_i(pc), .dx_req_i(dreq), .dx_wide_i(dwide),
    .dx_write_i(dwr), .dx_addr_i(daddr), .dx_wdata_i(dwd), .hi_reg_i(p2),
    .ale_o(ale), .psen_n_o(psen_n), .ad_o(ad), .ad_oe_o(ad_oe),
    .ahi_o(ahi), .ahi_oe_o(ahi_oe)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (ale !== e.ale || psen_n !== e.psen_n || ad_oe !== e.ad_oe ||
        ad !== e.ad || ahi_oe !== e.ahi_oe || ahi !== e.ahi) begin
      errors++;
      $display("FAIL %s got ale=%b psn=%b aoe=%b ad=%h hoe=%b ahi=%h exp ale=%b psn=%b aoe=%b ad=%h hoe=%b ahi=%h",
               e.tag, ale, psen_n, ad_oe, ad, ahi_oe, ahi,
               e.ale, e.psen_n, e.ad_oe, e.ad, e.ahi_oe, e.ahi);
    end
  endtask

  task automatic check_idle(input string tag);
    exp_t e;
    e.ale = 0; e.psen_n = 1; e.ad_oe = 0; e.ahi_oe = 0;
    e.ad = ad; e.ahi = ahi; e.tag = tag;
    compare(e);
  endtask

  // monitor: one expected item per clock, sampled mid high phase
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  // driver: apply one machine cycle of inputs and queue its expected slots
  task automatic mcycle(input bit x2, input bit e_a, input bit off,
                        input logic [15:0] p, input bit req, input bit wide,
                        input bit wr, input logic [15:0] a, input logic [7:0] wd,
                        input logic [7:0] hreg, input bit glitch, input string tag);
    int s_n, h, aw;
    bit ext;
    dbl = x2; ea = e_a; aoff = off; pc = p; dreq = req; dwide = wide;
    dwr = wr; daddr = a; dwd = wd; p2 = hreg;
    s_n = x2 ? 6 : 12;
    h   = s_n / 2;
    aw  = h / 3;
    ext = !e_a || (p > 16'h1FFF);
    for (int s = 0; s < s_n; s++) begin
      exp_t e;
      bit up, aslot, pslot;
      int q;
      up = (s >= h);
      q  = s % h;
      aslot = (q < aw);
      pslot = (q > aw);
      e.tag = tag;
      if (req) begin
        e.ale = aslot && !up; e.psen_n = 1;
        e.ad_oe = up ? wr : aslot;
        e.ad = !e.ad_oe ? 8'h00 : (up ? wd : a[7:0]);
        e.ahi_oe = 1; e.ahi = wide ? a[15:8] : hreg;
      end else begin
        e.ale = aslot && (ext || !off);
        e.psen_n = !(pslot && ext);
        e.ad_oe = aslot && ext;
        e.ad = e.ad_oe ? p[7:0] : 8'h00;
        e.ahi_oe = ext; e.ahi = ext ? p[15:8] : hreg;
      end
      sb.push_back(e);
    end
    if (glitch) begin
      repeat (3) @(negedge clk);
      dbl = ~x2; aoff = ~off; dreq = ~req;
      repeat (s_n - 4) @(negedge clk);
      dbl = x2; aoff = off; dreq = req;
      @(negedge clk);
    end else begin
      repeat (s_n) @(negedge clk);
    end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog R1 got hang exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    dbl = 1; dreq = 1; aoff = 1;
    repeat (3) @(negedge clk);
    check_idle("R1 reset idle");
    rst_n = 1'b1;
    // R2 R3 R7 R8: external fetch, normal speed
    mcycle(0, 0, 0, 16'h1234, 0, 0, 0, 16'h0, 8'h0, 8'h77, 0, "R2 R3 R7 R8 ext fetch");
    // R4: internal fetch, latch strobe still runs
    mcycle(0, 1, 0, 16'h0100, 0, 0, 0, 16'h0, 8'h0, 8'h66, 0, "R4 internal fetch");
    // R5: latch disable on internal fetch
    mcycle(0, 1, 1, 16'h0100, 0, 0, 0, 16'h0, 8'h0, 8'h66, 0, "R5 latch off internal");
    // R4 R5: above limit goes external even with disable set
    mcycle(0, 1, 1, 16'h2000, 0, 0, 0, 16'h0, 8'h0, 8'h55, 0, "R4 R5 above limit");
    // R6 R7 R8: wide read
    mcycle(0, 0, 0, 16'h1236, 1, 1, 0, 16'hBEEF, 8'h11, 8'h44, 0, "R6 R7 R8 wide read");
    // R6 R7 R8: narrow write
    mcycle(0, 0, 1, 16'h1238, 1, 0, 1, 16'h0042, 8'hC3, 8'h5A, 0, "R6 R7 R8 narrow write");
    // R2 R3 R10: double speed fetch
    mcycle(1, 0, 0, 16'hA5F0, 0, 0, 0, 16'h0, 8'h0, 8'h33, 0, "R2 R3 R10 x2 fetch");
    mcycle(1, 1, 1, 16'h0010, 0, 0, 0, 16'h0, 8'h0, 8'h22, 0, "R5 R10 x2 latch off");
    // R10: mode switch and data access on the same boundary
    mcycle(0, 0, 0, 16'h3000, 0, 0, 0, 16'h0, 8'h0, 8'h21, 0, "R10 back to normal");
    mcycle(1, 0, 0, 16'h3002, 1, 1, 1, 16'h9A7E, 8'h5D, 8'h20, 0, "R10 switch+data x2");
    mcycle(0, 0, 0, 16'h3004, 1, 0, 0, 16'h00F1, 8'h00, 8'hE7, 0, "R10 switch+data normal");
    // R9: mid-cycle toggles are ignored
    mcycle(0, 1, 0, 16'h0200, 0, 0, 0, 16'h0, 8'h0, 8'h99, 1, "R9 mid-cycle ignored");
    mcycle(1, 0, 1, 16'h4321, 0, 0, 0, 16'h0, 8'h0, 8'h98, 1, "R9 mid-cycle ignored x2");
    mcycle(0, 0, 0, 16'h1FFF, 0, 0, 0, 16'h0, 8'h0, 8'h12, 0, "R4 R8 ea low at limit");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_idle("R1 reset mid-run");
    @(negedge clk);
    check_idle("R1 reset held");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule